// File: doc/BRIEF.md
# Flash Interface Timing to Clock-Cycle Converter

This block turns the timing figures of a raw flash device interface into the clock-cycle counts that a static memory controller needs for one chip select. It receives every figure in picoseconds together with the controller clock period, also in picoseconds, and returns the strobe setup, pulse, hold and total counts for writes and reads. It also returns the chip-select pulse lengths, the bus turnaround (float) count and five command/address delay counts. Each figure is rounded up to whole cycles, so the programmed waveform never comes out shorter than the device demands.

A request enters through a valid/ready pair. The block accepts it only while idle (`in_ready` high), captures the inputs in the accepting cycle, and needs them no longer. It then runs thirteen ceiling divisions one after another through a single shared serial divider. The result stays on the outputs with `out_valid` high until the consumer raises `out_ready`. Back-pressure is complete: no new request is taken while a result is pending or a computation is running.

A request that cannot be served yields a status code with all count fields forced to zero. This happens for a double-data-rate interface, for a read cycle shorter than 30 ns (extended-output modes), for a zero clock period, or for a count that does not fit its field.

Top module: `flash_timing_calc`

## Requirements
- R1: `in_ready` is high only when no request is in progress or pending. A request is taken on a rising edge with `in_valid` and `in_ready` both high. The result is then held unchanged with `out_valid` high until an edge with `out_ready` high, after which `in_ready` is high again.
- R2: Every conversion yields ceil(time_ps / clk_period_ps). A time that is an exact multiple of the period gives the plain quotient, and one picosecond more adds one cycle.
- R3: `wr_pulse` = ceil(t_we_low). `wr_setup` = ceil of the largest of the command-latch, chip-enable, address-latch and data setup times, minus `wr_pulse`, floored at zero.
- R4: `wr_hold` = ceil of the largest of the command-latch, chip-enable, address-latch and data hold times and t_we_high. `wr_cycle` = max(ceil(t_wr_cycle), wr_setup + wr_pulse + wr_hold). `wr_cs_pulse` equals `wr_cycle`.
- R5: `rd_hold` = ceil(max(t_re_high, t_out_hold)). `rd_pulse` = ceil(t_re_low). `rd_cycle` = max(ceil(t_rd_cycle), rd_pulse + rd_hold). `rd_cs_pulse` equals `rd_cycle`. The read strobe setup is fixed at zero and has no field.
- R6: `float_cnt` = ceil(t_out_hiz) - rd_hold, where t_out_hiz is a maximum figure. The result is clamped to [FLOAT_MIN, FLOAT_MAX], 0 and 15 by default, including when the difference is negative.
- R7: The five delays (command-latch-to-read, address-to-data-load, address-latch-to-read, ready-to-read, write-to-busy) are each the ceiling conversion of their own input. The write-to-busy input is a maximum figure.
- R8: `out_status` = 1 (unsupported) when `sdr_mode` is 0, when t_rd_cycle < 30000 ps, or when the clock period is 0. t_rd_cycle = 30000 is supported. The result is presented in the cycle after acceptance with every count field zero.
- R9: `out_status` = 2 (overflow) when any count other than `float_cnt` exceeds 2^CW-1 (255 by default), with every count field zero. Status 0 means a valid configuration.
- R10: After reset `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| sdr_mode | input | 1 | 1 = single-data-rate interface |
| clk_period_ps | input | TW | Controller clock period |
| t_we_low | input | TW | Write strobe low time (min) |
| t_cle_setup | input | TW | Command latch setup (min) |
| t_ce_setup | input | TW | Chip enable setup (min) |
| t_ale_setup | input | TW | Address latch setup (min) |
| t_data_setup | input | TW | Data setup (min) |
| t_cle_hold | input | TW | Command latch hold (min) |
| t_ce_hold | input | TW | Chip enable hold (min) |
| t_ale_hold | input | TW | Address latch hold (min) |
| t_data_hold | input | TW | Data hold (min) |
| t_we_high | input | TW | Write strobe high time (min) |
| t_wr_cycle | input | TW | Write cycle time (min) |
| t_re_high | input | TW | Read strobe high time (min) |
| t_out_hold | input | TW | Output hold after read strobe (min) |
| t_out_hiz | input | TW | Output to high impedance (max) |
| t_re_low | input | TW | Read strobe low time (min) |
| t_rd_cycle | input | TW | Read cycle time (min) |
| t_cle_to_re | input | TW | Command latch to read strobe (min) |
| t_adr_to_load | input | TW | Address to data load (min) |
| t_ale_to_re | input | TW | Address latch to read strobe (min) |
| t_rdy_to_re | input | TW | Ready to read strobe (min) |
| t_we_to_busy | input | TW | Write strobe to busy (max) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_status | output | 2 | 0 ok, 1 unsupported, 2 overflow |
| wr_setup | output | CW | Write strobe setup cycles |
| wr_pulse | output | CW | Write strobe pulse cycles |
| wr_hold | output | CW | Write strobe hold cycles |
| wr_cycle | output | CW | Write total cycles |
| wr_cs_pulse | output | CW | Chip-select pulse on writes |
| rd_pulse | output | CW | Read strobe pulse cycles |
| rd_hold | output | CW | Read strobe hold cycles |
| rd_cycle | output | CW | Read total cycles |
| rd_cs_pulse | output | CW | Chip-select pulse on reads |
| float_cnt | output | clog2(FLOAT_MAX+1) | Bus turnaround cycles |
| dly_cle_re | output | CW | Command-latch-to-read delay |
| dly_adr_load | output | CW | Address-to-data-load delay |
| dly_ale_re | output | CW | Address-latch-to-read delay |
| dly_rdy_re | output | CW | Ready-to-read delay |
| dly_we_busy | output | CW | Write-to-busy delay |

## Verification
The main function is tried with several parameter sets. In one, the largest setup time is below the write pulse, which tells the zero floor apart from a plain subtraction. In another, the setup dominates and the write cycle time rather than the summed phases sets the total. The float count is driven both above its ceiling and below zero, which separates the two clamp arms from the unclamped middle. Times one picosecond over a period multiple and exactly on one distinguish ceiling from floor. The boundaries 255 against 256 cycles and 30000 against 29999 ps separate the overflow and unsupported limits from off-by-one variants. Results held under back-pressure show whether the output and `in_ready` respect the handshake.

// File: rtl/flash_tc_pkg.sv
package flash_tc_pkg;
  localparam int unsigned NOPS = 13;          // divisions per request
  localparam int unsigned MIN_RC_PS = 30000;  // shortest supported read cycle

  // operand slots, in the order the divider walks them
  localparam int unsigned OP_WPULSE = 0;
  localparam int unsigned OP_WSETUP = 1;
  localparam int unsigned OP_WHOLD  = 2;
  localparam int unsigned OP_WCYC   = 3;
  localparam int unsigned OP_RHOLD  = 4;
  localparam int unsigned OP_HIZ    = 5;
  localparam int unsigned OP_RPULSE = 6;
  localparam int unsigned OP_RCYC   = 7;
  localparam int unsigned OP_D0     = 8;  // five delays follow

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_UNSUP = 2'd1,
    ST_OVF   = 2'd2
  } status_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RUN  = 2'd1,
    S_HOLD = 2'd2
  } fsm_e;
endpackage

// File: rtl/flash_tc_opsel.sv
// Reduces the raw figures to the thirteen dividends (worst-case maxima).
module flash_tc_opsel
  import flash_tc_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic [TW-1:0] t_we_low,
  input  logic [TW-1:0] t_cle_setup,
  input  logic [TW-1:0] t_ce_setup,
  input  logic [TW-1:0] t_ale_setup,
  input  logic [TW-1:0] t_data_setup,
  input  logic [TW-1:0] t_cle_hold,
  input  logic [TW-1:0] t_ce_hold,
  input  logic [TW-1:0] t_ale_hold,
  input  logic [TW-1:0] t_data_hold,
  input  logic [TW-1:0] t_we_high,
  input  logic [TW-1:0] t_wr_cycle,
  input  logic [TW-1:0] t_re_high,
  input  logic [TW-1:0] t_out_hold,
  input  logic [TW-1:0] t_out_hiz,
  input  logic [TW-1:0] t_re_low,
  input  logic [TW-1:0] t_rd_cycle,
  input  logic [TW-1:0] t_cle_to_re,
  input  logic [TW-1:0] t_adr_to_load,
  input  logic [TW-1:0] t_ale_to_re,
  input  logic [TW-1:0] t_rdy_to_re,
  input  logic [TW-1:0] t_we_to_busy,
  output logic [NOPS-1:0][TW-1:0] ops
);
  function automatic logic [TW-1:0] mx(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    ops = '0;
    ops[OP_WPULSE] = t_we_low;
    ops[OP_WSETUP] = mx(mx(t_cle_setup, t_ce_setup), mx(t_ale_setup, t_data_setup));
    ops[OP_WHOLD]  = mx(mx(mx(t_cle_hold, t_ce_hold), mx(t_ale_hold, t_data_hold)), t_we_high);
    ops[OP_WCYC]   = t_wr_cycle;
    ops[OP_RHOLD]  = mx(t_re_high, t_out_hold);
    ops[OP_HIZ]    = t_out_hiz;
    ops[OP_RPULSE] = t_re_low;
    ops[OP_RCYC]   = t_rd_cycle;
    ops[OP_D0]     = t_cle_to_re;
    ops[OP_D0+1]   = t_adr_to_load;
    ops[OP_D0+2]   = t_ale_to_re;
    ops[OP_D0+3]   = t_rdy_to_re;
    ops[OP_D0+4]   = t_we_to_busy;
  end
endmodule

// File: rtl/flash_tc_ceildiv.sv
// Serial restoring divider returning ceil(num/den); one quotient bit per cycle.
module flash_tc_ceildiv #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot
);
  localparam int CNTW = $clog2(W + 1);

  logic [W-1:0]    q_q, r_q, d_q;
  logic [CNTW-1:0] cnt_q;
  logic            busy_q;
  logic [W:0]      r_sh;
  logic            take;

  assign r_sh = {r_q, q_q[W-1]};
  assign take = (r_sh >= {1'b0, d_q});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q    <= '0;
      r_q    <= '0;
      d_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      q_q    <= num;
      r_q    <= '0;
      d_q    <= den;
      cnt_q  <= CNTW'(W);
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q != '0) begin
        r_q   <= take ? W'(r_sh - {1'b0, d_q}) : r_sh[W-1:0];
        q_q   <= {q_q[W-2:0], take};
        cnt_q <= cnt_q - 1'b1;
      end else begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
  assign quot = q_q + W'(r_q != '0);
endmodule

// File: rtl/flash_tc_fields.sv
// Combines the converted counts into fields, clamps float, flags overflow.
module flash_tc_fields
  import flash_tc_pkg::*;
#(
  parameter int TW        = 32,
  parameter int CW        = 8,
  parameter int FLOAT_MIN = 0,
  parameter int FLOAT_MAX = 15,
  parameter int FW        = 4
) (
  input  logic [NOPS-1:0][TW-1:0] cyc,
  output logic [CW-1:0] wr_setup,
  output logic [CW-1:0] wr_pulse,
  output logic [CW-1:0] wr_hold,
  output logic [CW-1:0] wr_cycle,
  output logic [CW-1:0] rd_pulse,
  output logic [CW-1:0] rd_hold,
  output logic [CW-1:0] rd_cycle,
  output logic [FW-1:0] float_cnt,
  output logic [4:0][CW-1:0] dly,
  output logic          ovf
);
  localparam int XW = TW + 2;
  localparam logic [XW-1:0] FMAX = XW'((64'd1 << CW) - 64'd1);
  localparam int NCHK = 12;

  logic [XW-1:0] c [NOPS];
  logic [XW-1:0] wsu, wsum, wcy, rsum, rcy, flt;
  logic [XW-1:0] chk [NCHK];

  for (genvar i = 0; i < NOPS; i++) begin : g_ext
    assign c[i] = XW'(cyc[i]);
  end

  always_comb begin
    wsu  = (c[OP_WSETUP] > c[OP_WPULSE]) ? c[OP_WSETUP] - c[OP_WPULSE] : '0;
    wsum = wsu + c[OP_WPULSE] + c[OP_WHOLD];
    wcy  = (c[OP_WCYC] > wsum) ? c[OP_WCYC] : wsum;
    rsum = c[OP_RPULSE] + c[OP_RHOLD];
    rcy  = (c[OP_RCYC] > rsum) ? c[OP_RCYC] : rsum;
    // float = hi-z minus read hold, clamped (signed-safe via comparison)
    if (c[OP_HIZ] <= c[OP_RHOLD] + XW'(FLOAT_MIN))
      flt = XW'(FLOAT_MIN);
    else if (c[OP_HIZ] - c[OP_RHOLD] > XW'(FLOAT_MAX))
      flt = XW'(FLOAT_MAX);
    else
      flt = c[OP_HIZ] - c[OP_RHOLD];
  end

  always_comb begin
    chk[0] = wsu;          chk[1] = c[OP_WPULSE]; chk[2] = c[OP_WHOLD];
    chk[3] = wcy;          chk[4] = c[OP_RPULSE]; chk[5] = c[OP_RHOLD];
    chk[6] = rcy;
    for (int i = 0; i < 5; i++) chk[7+i] = c[OP_D0+i];
    ovf = 1'b0;
    for (int i = 0; i < NCHK; i++) ovf = ovf | (chk[i] > FMAX);
  end

  assign wr_setup  = wsu[CW-1:0];
  assign wr_pulse  = c[OP_WPULSE][CW-1:0];
  assign wr_hold   = c[OP_WHOLD][CW-1:0];
  assign wr_cycle  = wcy[CW-1:0];
  assign rd_pulse  = c[OP_RPULSE][CW-1:0];
  assign rd_hold   = c[OP_RHOLD][CW-1:0];
  assign rd_cycle  = rcy[CW-1:0];
  assign float_cnt = flt[FW-1:0];
  for (genvar i = 0; i < 5; i++) begin : g_dly
    assign dly[i] = c[OP_D0+i][CW-1:0];
  end
endmodule

// File: rtl/flash_timing_calc.sv
module flash_timing_calc
  import flash_tc_pkg::*;
#(
  parameter int TW        = 32,
  parameter int CW        = 8,
  parameter int FLOAT_MIN = 0,
  parameter int FLOAT_MAX = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          sdr_mode,
  input  logic [TW-1:0] clk_period_ps,
  input  logic [TW-1:0] t_we_low,
  input  logic [TW-1:0] t_cle_setup,
  input  logic [TW-1:0] t_ce_setup,
  input  logic [TW-1:0] t_ale_setup,
  input  logic [TW-1:0] t_data_setup,
  input  logic [TW-1:0] t_cle_hold,
  input  logic [TW-1:0] t_ce_hold,
  input  logic [TW-1:0] t_ale_hold,
  input  logic [TW-1:0] t_data_hold,
  input  logic [TW-1:0] t_we_high,
  input  logic [TW-1:0] t_wr_cycle,
  input  logic [TW-1:0] t_re_high,
  input  logic [TW-1:0] t_out_hold,
  input  logic [TW-1:0] t_out_hiz,
  input  logic [TW-1:0] t_re_low,
  input  logic [TW-1:0] t_rd_cycle,
  input  logic [TW-1:0] t_cle_to_re,
  input  logic [TW-1:0] t_adr_to_load,
  input  logic [TW-1:0] t_ale_to_re,
  input  logic [TW-1:0] t_rdy_to_re,
  input  logic [TW-1:0] t_we_to_busy,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [1:0]    out_status,
  output logic [CW-1:0] wr_setup,
  output logic [CW-1:0] wr_pulse,
  output logic [CW-1:0] wr_hold,
  output logic [CW-1:0] wr_cycle,
  output logic [CW-1:0] wr_cs_pulse,
  output logic [CW-1:0] rd_pulse,
  output logic [CW-1:0] rd_hold,
  output logic [CW-1:0] rd_cycle,
  output logic [CW-1:0] rd_cs_pulse,
  output logic [$clog2(FLOAT_MAX+1)-1:0] float_cnt,
  output logic [CW-1:0] dly_cle_re,
  output logic [CW-1:0] dly_adr_load,
  output logic [CW-1:0] dly_ale_re,
  output logic [CW-1:0] dly_rdy_re,
  output logic [CW-1:0] dly_we_busy
);
  localparam int FW = $clog2(FLOAT_MAX + 1);
  localparam int KW = $clog2(NOPS);

  fsm_e                    state_q;
  logic [KW-1:0]           k_q;
  logic                    issue_q, unsup_q;
  logic [NOPS-1:0][TW-1:0] ops_in, ops_q, cyc_q;
  logic [TW-1:0]           per_q;
  logic                    accept, bad_mode;
  logic                    div_start, div_busy, div_done;
  logic [TW-1:0]           div_quot;
  logic                    f_ovf, cfg_ok;
  logic [CW-1:0]           f_wsu, f_wpl, f_who, f_wcy, f_rpl, f_rho, f_rcy;
  logic [FW-1:0]           f_flt;
  logic [4:0][CW-1:0]      f_dly;

  flash_tc_opsel #(.TW(TW)) u_opsel (
    .t_we_low(t_we_low), .t_cle_setup(t_cle_setup), .t_ce_setup(t_ce_setup),
    .t_ale_setup(t_ale_setup), .t_data_setup(t_data_setup),
    .t_cle_hold(t_cle_hold), .t_ce_hold(t_ce_hold), .t_ale_hold(t_ale_hold),
    .t_data_hold(t_data_hold), .t_we_high(t_we_high), .t_wr_cycle(t_wr_cycle),
    .t_re_high(t_re_high), .t_out_hold(t_out_hold), .t_out_hiz(t_out_hiz),
    .t_re_low(t_re_low), .t_rd_cycle(t_rd_cycle), .t_cle_to_re(t_cle_to_re),
    .t_adr_to_load(t_adr_to_load), .t_ale_to_re(t_ale_to_re),
    .t_rdy_to_re(t_rdy_to_re), .t_we_to_busy(t_we_to_busy), .ops(ops_in)
  );

  assign in_ready  = (state_q == S_IDLE);
  assign out_valid = (state_q == S_HOLD);
  assign accept    = in_valid && in_ready;
  // R8: non-SDR, too-fast read cycle or zero period cannot be served
  assign bad_mode  = !sdr_mode || (t_rd_cycle < TW'(MIN_RC_PS)) || (clk_period_ps == '0);
  assign div_start = (state_q == S_RUN) && issue_q;

  flash_tc_ceildiv #(.W(TW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(ops_q[k_q]), .den(per_q),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      k_q     <= '0;
      issue_q <= 1'b0;
      unsup_q <= 1'b0;
      ops_q   <= '0;
      cyc_q   <= '0;
      per_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (accept) begin
          ops_q   <= ops_in;
          per_q   <= clk_period_ps;
          k_q     <= '0;
          unsup_q <= bad_mode;
          issue_q <= !bad_mode;
          state_q <= bad_mode ? S_HOLD : S_RUN;
        end
        S_RUN: begin
          if (div_start) issue_q <= 1'b0;
          if (div_done && !div_start) begin
            cyc_q[k_q] <= div_quot;
            if (k_q == KW'(NOPS - 1)) begin
              state_q <= S_HOLD;
            end else begin
              k_q     <= k_q + 1'b1;
              issue_q <= 1'b1;
            end
          end
        end
        S_HOLD: if (out_ready) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  flash_tc_fields #(
    .TW(TW), .CW(CW), .FLOAT_MIN(FLOAT_MIN), .FLOAT_MAX(FLOAT_MAX), .FW(FW)
  ) u_fields (
    .cyc(cyc_q), .wr_setup(f_wsu), .wr_pulse(f_wpl), .wr_hold(f_who),
    .wr_cycle(f_wcy), .rd_pulse(f_rpl), .rd_hold(f_rho), .rd_cycle(f_rcy),
    .float_cnt(f_flt), .dly(f_dly), .ovf(f_ovf)
  );

  // R8/R9: a refused request carries no configuration
  assign cfg_ok     = out_valid && !unsup_q && !f_ovf && !div_busy;
  assign out_status = !out_valid ? ST_OK : unsup_q ? ST_UNSUP : f_ovf ? ST_OVF : ST_OK;

  assign wr_setup     = cfg_ok ? f_wsu : '0;
  assign wr_pulse     = cfg_ok ? f_wpl : '0;
  assign wr_hold      = cfg_ok ? f_who : '0;
  assign wr_cycle     = cfg_ok ? f_wcy : '0;
  assign wr_cs_pulse  = cfg_ok ? f_wcy : '0;
  assign rd_pulse     = cfg_ok ? f_rpl : '0;
  assign rd_hold      = cfg_ok ? f_rho : '0;
  assign rd_cycle     = cfg_ok ? f_rcy : '0;
  assign rd_cs_pulse  = cfg_ok ? f_rcy : '0;
  assign float_cnt    = cfg_ok ? f_flt : '0;
  assign dly_cle_re   = cfg_ok ? f_dly[0] : '0;
  assign dly_adr_load = cfg_ok ? f_dly[1] : '0;
  assign dly_ale_re   = cfg_ok ? f_dly[2] : '0;
  assign dly_rdy_re   = cfg_ok ? f_dly[3] : '0;
  assign dly_we_busy  = cfg_ok ? f_dly[4] : '0;
endmodule

// File: rtl/flash_tc_chk.sv
module flash_tc_chk #(
  parameter int CW        = 8,
  parameter int FW        = 4,
  parameter int FLOAT_MIN = 0,
  parameter int FLOAT_MAX = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_status,
  input logic [CW-1:0] wr_setup,
  input logic [CW-1:0] wr_pulse,
  input logic [CW-1:0] wr_hold,
  input logic [CW-1:0] wr_cycle,
  input logic [CW-1:0] rd_pulse,
  input logic [CW-1:0] rd_hold,
  input logic [CW-1:0] rd_cycle,
  input logic [FW-1:0] float_cnt
);
  a_r1_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r1_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_status) &&
      $stable(wr_cycle) && $stable(rd_cycle) && $stable(float_cnt)));

  a_r4_wr_total: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd0) |->
      ({2'b00, wr_cycle} >= {2'b00, wr_setup} + {2'b00, wr_pulse} + {2'b00, wr_hold}));

  a_r5_rd_total: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd0) |->
      ({1'b0, rd_cycle} >= {1'b0, rd_pulse} + {1'b0, rd_hold}));

  a_r6_float_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status == 2'd0) |->
      (int'(float_cnt) >= FLOAT_MIN && int'(float_cnt) <= FLOAT_MAX));

  a_r8_no_config: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_status != 2'd0) |->
      (wr_cycle == '0 && rd_cycle == '0 && wr_pulse == '0 && float_cnt == '0));

  a_r9_status_code: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_status != 2'd3));

  a_r10_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid));
endmodule

bind flash_timing_calc flash_tc_chk #(
  .CW(CW), .FW(FW), .FLOAT_MIN(FLOAT_MIN), .FLOAT_MAX(FLOAT_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_status(out_status), .wr_setup(wr_setup),
  .wr_pulse(wr_pulse), .wr_hold(wr_hold), .wr_cycle(wr_cycle),
  .rd_pulse(rd_pulse), .rd_hold(rd_hold), .rd_cycle(rd_cycle),
  .float_cnt(float_cnt)
);

// File: tb/sim_flash_timing_calc.sv
`timescale 1ns/1ps
module sim_flash_timing_calc;
  localparam int TW = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic in_valid = 1'b0, out_ready = 1'b0, sdr_mode = 1'b1;
  logic [TW-1:0] per, wlo, cls, cs, als, ds, clh, ch, alh, dh, whi, wc;
  logic [TW-1:0] reh, rhoh, rhz, rp, rc, clr, adl, ar, rr, wb;
  logic in_ready, out_valid;
  logic [1:0] out_status;
  logic [CW-1:0] wr_setup, wr_pulse, wr_hold, wr_cycle, wr_cs_pulse;
  logic [CW-1:0] rd_pulse, rd_hold, rd_cycle, rd_cs_pulse;
  logic [3:0] float_cnt;
  logic [CW-1:0] dly_cle_re, dly_adr_load, dly_ale_re, dly_rdy_re, dly_we_busy;

  flash_timing_calc u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .sdr_mode(sdr_mode), .clk_period_ps(per), .t_we_low(wlo), .t_cle_setup(cls),
    .t_ce_setup(cs), .t_ale_setup(als), .t_data_setup(ds), .t_cle_hold(clh),
    .t_ce_hold(ch), .t_ale_hold(alh), .t_data_hold(dh), .t_we_high(whi),
    .t_wr_cycle(wc), .t_re_high(reh), .t_out_hold(rhoh), .t_out_hiz(rhz),
    .t_re_low(rp), .t_rd_cycle(rc), .t_cle_to_re(clr), .t_adr_to_load(adl),
    .t_ale_to_re(ar), .t_rdy_to_re(rr), .t_we_to_busy(wb),
    .out_valid(out_valid), .out_ready(out_ready), .out_status(out_status),
    .wr_setup(wr_setup), .wr_pulse(wr_pulse), .wr_hold(wr_hold),
    .wr_cycle(wr_cycle), .wr_cs_pulse(wr_cs_pulse), .rd_pulse(rd_pulse),
    .rd_hold(rd_hold), .rd_cycle(rd_cycle), .rd_cs_pulse(rd_cs_pulse),
    .float_cnt(float_cnt), .dly_cle_re(dly_cle_re), .dly_adr_load(dly_adr_load),
    .dly_ale_re(dly_ale_re), .dly_rdy_re(dly_rdy_re), .dly_we_busy(dly_we_busy)
  );

  int checks = 0, fails = 0;
  bit busy_m = 1'b0, done_flag = 1'b0;
  longint cyc_cnt = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
      finish_up();
    end
  end

  // R1 per-clock model: ready only when nothing is outstanding
  always @(negedge clk) if (rst_n) begin
    chk("R1", "in_ready per clock", longint'(in_ready), longint'(!busy_m));
    if (!busy_m) chk("R1", "out_valid while idle", longint'(out_valid), 0);
  end

  function automatic longint cd(input longint t);
    return (t + longint'(per) - 1) / longint'(per);
  endfunction
  function automatic longint mx(input longint a, input longint b);
    return (a > b) ? a : b;
  endfunction

  task automatic set_base();
    sdr_mode = 1'b1; per = 5000;
    wlo = 25000; cls = 12000; cs = 20000; als = 12000; ds = 12000;
    clh = 5000; ch = 5000; alh = 5000; dh = 5000; whi = 10000; wc = 30000;
    reh = 10000; rhoh = 15000; rhz = 100000; rp = 15001; rc = 30000;
    clr = 10000; adl = 70000; ar = 10000; rr = 20000; wb = 100000;
  endtask

  task automatic run(input string name, input int hold);
    longint e_wp, e_ws, e_wh, e_wc, e_rh, e_rp, e_rc, e_fl, e_st, fl_raw;
    longint e_d [5];
    int n;
    logic [1:0] st0;
    // reference model
    if (!sdr_mode || rc < 30000 || per == 0) e_st = 1;
    else begin
      e_wp = cd(wlo);
      e_ws = mx(cd(mx(mx(cls, cs), mx(als, ds))) - e_wp, 0);
      e_wh = cd(mx(mx(mx(clh, ch), mx(alh, dh)), whi));
      e_wc = mx(cd(wc), e_ws + e_wp + e_wh);
      e_rh = cd(mx(reh, rhoh));
      e_rp = cd(rp);
      e_rc = mx(cd(rc), e_rp + e_rh);
      fl_raw = cd(rhz) - e_rh;
      e_fl = (fl_raw < 0) ? 0 : (fl_raw > 15) ? 15 : fl_raw;
      e_d[0] = cd(clr); e_d[1] = cd(adl); e_d[2] = cd(ar); e_d[3] = cd(rr); e_d[4] = cd(wb);
      e_st = 0;
      if (e_ws > 255 || e_wp > 255 || e_wh > 255 || e_wc > 255 ||
          e_rh > 255 || e_rp > 255 || e_rc > 255) e_st = 2;
      for (int i = 0; i < 5; i++) if (e_d[i] > 255) e_st = 2;
    end
    if (e_st != 0) begin
      e_wp = 0; e_ws = 0; e_wh = 0; e_wc = 0; e_rh = 0; e_rp = 0; e_rc = 0; e_fl = 0;
      for (int i = 0; i < 5; i++) e_d[i] = 0;
    end
    // drive request
    @(negedge clk);
    in_valid = 1'b1;
    @(posedge clk);
    busy_m = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n = 0;
    while (!out_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (e_st == 1) chk("R8", {name, " latency"}, n, 0);
    chk("R9", {name, " status"}, longint'(out_status), e_st);
    chk("R3", {name, " wr_pulse"}, longint'(wr_pulse), e_wp);
    chk("R3", {name, " wr_setup"}, longint'(wr_setup), e_ws);
    chk("R4", {name, " wr_hold"}, longint'(wr_hold), e_wh);
    chk("R4", {name, " wr_cycle"}, longint'(wr_cycle), e_wc);
    chk("R4", {name, " wr_cs_pulse"}, longint'(wr_cs_pulse), e_wc);
    chk("R5", {name, " rd_hold"}, longint'(rd_hold), e_rh);
    chk("R5", {name, " rd_pulse"}, longint'(rd_pulse), e_rp);
    chk("R5", {name, " rd_cycle"}, longint'(rd_cycle), e_rc);
    chk("R5", {name, " rd_cs_pulse"}, longint'(rd_cs_pulse), e_rc);
    chk("R6", {name, " float_cnt"}, longint'(float_cnt), e_fl);
    chk("R7", {name, " dly_cle_re"}, longint'(dly_cle_re), e_d[0]);
    chk("R7", {name, " dly_adr_load"}, longint'(dly_adr_load), e_d[1]);
    chk("R7", {name, " dly_ale_re"}, longint'(dly_ale_re), e_d[2]);
    chk("R7", {name, " dly_rdy_re"}, longint'(dly_rdy_re), e_d[3]);
    chk("R7", {name, " dly_we_busy"}, longint'(dly_we_busy), e_d[4]);
    st0 = out_status;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R1", {name, " held valid"}, longint'(out_valid), 1);
      chk("R1", {name, " held status"}, longint'(out_status), longint'(st0));
      chk("R1", {name, " held rd_cycle"}, longint'(rd_cycle), e_rc);
    end
    out_ready = 1'b1;
    @(posedge clk);
    busy_m = 1'b0;
    @(negedge clk);
    out_ready = 1'b0;
    chk("R1", {name, " ready after handshake"}, longint'(in_ready), 1);
  endtask

  initial begin
    set_base();
    repeat (3) @(negedge clk);
    chk("R10", "in_ready in reset", longint'(in_ready), 1);
    chk("R10", "out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "in_ready after reset", longint'(in_ready), 1);

    // R3 setup floors at zero, R6 float clamps high, R8 rc=30000 accepted, R2 rp 15001 rounds up
    set_base();
    run("base", 0);
    // R3 setup exceeds pulse, R4 write cycle time dominates, R6 float mid-range, with back-pressure
    set_base();
    per = 7500; wlo = 10000; cs = 40000; wc = 120000; rhz = 60000; rc = 90000;
    run("setup_dom", 4);
    // R6 negative float clamps to zero
    set_base();
    rhz = 1000; reh = 40000;
    run("float_neg", 0);
    // R2 exact multiples give plain quotient
    set_base();
    per = 2500; clr = 25000; ar = 25001; rr = 2500; wb = 2499;
    run("exact", 1);
    // R8 double data rate refused
    set_base();
    sdr_mode = 1'b0;
    run("ddr", 2);
    // R8 read cycle 1 ps short
    set_base();
    rc = 29999;
    run("rc_short", 0);
    // R8 zero clock period
    set_base();
    per = 0;
    run("per_zero", 0);
    // R9 boundary 255 fits
    set_base();
    per = 7500; adl = 255 * 7500;
    run("fit255", 0);
    // R9 256 overflows
    set_base();
    per = 7500; adl = 255 * 7500 + 1;
    run("ovf256", 2);
    // R9 overflow in summed write cycle
    set_base();
    wlo = 200 * 5000; whi = 60 * 5000;
    run("ovf_sum", 0);
    // R7 write-to-busy only, all others small
    set_base();
    per = 3000; wb = 200000;
    run("busy_max", 0);
    finish_up();
  end
endmodule